// File: doc/BRIEF.md
# Double-Buffered Ethernet Frame Buffer

This block is the packet store between a minimal 10Base-T MAC and a small 16-bit processor. The MAC side moves one byte at a time. The processor sees every buffer and control register as a 16-bit word on its memory-mapped bus, and it finds arriving frames by polling. The block does not raise an interrupt.

Receive storage is two equal banks used in strict alternation. The MAC writes a frame into one bank while software reads the previous frame out of the other. A finished frame stays readable until software releases it. If the next bank in turn is still held, the arriving frame is discarded and a saturating overflow count is incremented.

Transmit storage is one bank. Software loads the bank, then writes the frame length. The block then hands the bytes to the MAC in order, using a valid/ready handshake.

The receive sequencer has three states:
- RX_IDLE waits for a first byte. It goes to RX_FILL when the bank in turn is free ("accept"). It goes to RX_DROP when that bank is held ("reject"). A one-byte frame completes without leaving RX_IDLE.
- RX_FILL returns to RX_IDLE on the last byte ("complete").
- RX_DROP returns to RX_IDLE on the last byte ("discard end").

The transmit sequencer has two states:
- TX_IDLE goes to TX_SEND on a valid length write ("launch").
- TX_SEND goes back to TX_IDLE when the final byte is accepted ("finish").

Top module: `efb_frame_buffer`

## Requirements

In what follows, W = BANK_BYTES/2. The processor address map is:
- receive window: word addresses 0 to W-1;
- transmit window: word addresses W to 2W-1;
- registers: word address 2W+k, where k=0 is status, k=1 is receive length, k=2 is release, k=3 is transmit length and k=4 is the overflow count.

- R1: After reset, the following read as zero: status, receive length and overflow count. tx_valid is low.
- R2: A frame is a run of rx_valid bytes ending with rx_last. When it completes into a free bank, status bit 0 (ready) reads 1 and the receive length reads the byte count. Receive window word i returns byte 2i in bits 7:0 and byte 2i+1 in bits 15:8.
- R3: A second frame that completes while the first is unreleased lands in the other bank. Frames are read out in arrival order: after the first is released, the second's data and length are visible.
- R4: Any write to the release register while ready is 1 frees the oldest frame and exposes the next one. The same write while ready is 0 has no effect on later frame order or contents.
- R5: A frame that starts while the bank in turn is still held is discarded whole. The held frames are left unchanged and the overflow count increments by one. The count saturates at all ones.
- R6: A frame longer than BANK_BYTES keeps its first BANK_BYTES bytes, reports a length of BANK_BYTES, and sets status bit 1 (error). That bit is 0 for frames of BANK_BYTES bytes or fewer.
- R7: Writing a transmit length L, with 1 ≤ L ≤ BANK_BYTES, while idle sets status bit 2 (busy). The block then presents L bytes in order: the low byte of each transmit word first, then the high byte. tx_last is high only on byte L.
- R8: While tx_valid is high and tx_ready is low, tx_data and tx_last hold. Busy and tx_valid are low in the cycle after the handshake of the final byte.
- R9: A transmit length write is ignored if it arrives while busy, if it is 0, or if it is above BANK_BYTES. The frame in progress keeps its length, and no transmission starts.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_we | input | 1 | Processor write strobe |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data, combinational from cpu_addr |
| rx_valid | input | 1 | Receive byte present |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final transmit byte |
| tx_ready | input | 1 | MAC accepts the transmit byte |

## Verification

The assertions assume the following about the inputs:
- rx_last is meaningful only together with rx_valid;
- the processor issues at most one write per cycle;
- BANK_BYTES is a power of two;
- OVF_W is no wider than the data bus.

The stimulus follows these rules:
- It drives every input at the falling clock edge.
- It lowers rx_valid between frames.
- It never releases a bank in the same cycle that a frame begins.
- It applies MAC backpressure on a fixed stall pattern, so the hold property is exercised in every transmission.

// File: rtl/efb_pkg.sv
package efb_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_DROP} rx_state_e;
    typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;

    localparam int REG_STATUS  = 0;
    localparam int REG_RXLEN   = 1;
    localparam int REG_RELEASE = 2;
    localparam int REG_TXLEN   = 3;
    localparam int REG_OVF     = 4;

    localparam int ST_READY = 0;
    localparam int ST_ERR   = 1;
    localparam int ST_BUSY  = 2;
endpackage

// File: rtl/efb_rx_banks.sv
module efb_rx_banks
    import efb_pkg::*;
#(
    parameter int BANK_BYTES = 2048,
    parameter int OVF_W      = 16,
    localparam int WORDS  = BANK_BYTES / 2,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int LEN_W  = $clog2(BANK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              release_req,
    input  logic [WIDX_W-1:0] rd_widx,
    output logic [15:0]       rd_word,
    output logic              rd_ready,
    output logic              rd_err,
    output logic [LEN_W-1:0]  rd_len,
    output logic [OVF_W-1:0]  ovf_count
);
    rx_state_e        st_q, st_d;
    logic             wr_bank_q, rd_bank_q;
    logic [1:0]       full_q, err_q;
    logic [LEN_W-1:0] len_q [2];
    logic [LEN_W-1:0] cnt_q;
    logic             trunc_q;
    logic [OVF_W-1:0] ovf_q;
    logic [7:0]       mem_lo [2*WORDS];
    logic [7:0]       mem_hi [2*WORDS];

    logic             wr_en, frm_start, frm_done, frm_drop, at_cap, fin_err;
    logic [WIDX_W:0]  wr_pos;
    logic [LEN_W-1:0] fin_len;

    assign at_cap = (cnt_q == LEN_W'(BANK_BYTES));

    // next state and strobes
    always_comb begin
        st_d      = st_q;
        wr_en     = 1'b0;
        wr_pos    = cnt_q[WIDX_W:0];
        frm_start = 1'b0;
        frm_done  = 1'b0;
        frm_drop  = 1'b0;
        unique case (st_q)
            RX_IDLE: begin
                if (rx_valid) begin
                    if (!full_q[wr_bank_q]) begin
                        frm_start = 1'b1;
                        wr_en     = 1'b1;
                        wr_pos    = '0;
                        if (rx_last) frm_done = 1'b1;
                        else         st_d     = RX_FILL;
                    end else begin
                        frm_drop = 1'b1;
                        if (!rx_last) st_d = RX_DROP;
                    end
                end
            end
            RX_FILL: begin
                if (rx_valid) begin
                    wr_en = !at_cap;
                    if (rx_last) begin
                        frm_done = 1'b1;
                        st_d     = RX_IDLE;
                    end
                end
            end
            RX_DROP: begin
                if (rx_valid && rx_last) st_d = RX_IDLE;
            end
            default: st_d = RX_IDLE;
        endcase
    end

    always_comb begin
        if (frm_start)   fin_len = LEN_W'(1);
        else if (at_cap) fin_len = cnt_q;
        else             fin_len = cnt_q + LEN_W'(1);
        fin_err = !frm_start && (trunc_q || at_cap);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank_q <= 1'b0;
            rd_bank_q <= 1'b0;
            full_q    <= '0;
            err_q     <= '0;
            len_q[0]  <= '0;
            len_q[1]  <= '0;
            cnt_q     <= '0;
            trunc_q   <= 1'b0;
            ovf_q     <= '0;
        end else begin
            if (frm_start) begin
                cnt_q   <= LEN_W'(1);
                trunc_q <= 1'b0;
            end else if (st_q == RX_FILL && rx_valid) begin
                if (!at_cap) cnt_q   <= cnt_q + LEN_W'(1);
                else         trunc_q <= 1'b1;
            end
            if (release_req && full_q[rd_bank_q]) begin
                full_q[rd_bank_q] <= 1'b0;
                rd_bank_q         <= ~rd_bank_q;
            end
            if (frm_done) begin
                full_q[wr_bank_q] <= 1'b1;
                err_q[wr_bank_q]  <= fin_err;
                len_q[wr_bank_q]  <= fin_len;
                wr_bank_q         <= ~wr_bank_q;
            end
            if (frm_drop && ovf_q != '1) ovf_q <= ovf_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_pos[0]) mem_hi[{wr_bank_q, wr_pos[WIDX_W:1]}] <= rx_data;
            else           mem_lo[{wr_bank_q, wr_pos[WIDX_W:1]}] <= rx_data;
        end
    end

    assign rd_word   = {mem_hi[{rd_bank_q, rd_widx}], mem_lo[{rd_bank_q, rd_widx}]};
    assign rd_ready  = full_q[rd_bank_q];
    assign rd_err    = err_q[rd_bank_q];
    assign rd_len    = len_q[rd_bank_q];
    assign ovf_count = ovf_q;

    // R2: a completed frame stays held until software releases that bank
    for (genvar b = 0; b < 2; b++) begin : g_hold
        a_r2_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
            full_q[b] && !(release_req && rd_bank_q == 1'(b)) |=> full_q[b]);
    end

    // R5: no byte ever lands in a held bank
    a_r5_no_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full_q[wr_bank_q]);

    // R5: overflow count only steps up by one
    a_r5_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q != $past(ovf_q) |-> ovf_q == $past(ovf_q) + 1'b1);

    // R6: reported length never exceeds the bank
    a_r6_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rd_len <= LEN_W'(BANK_BYTES));
endmodule

// File: rtl/efb_tx_drain.sv
module efb_tx_drain
    import efb_pkg::*;
#(
    parameter int BANK_BYTES = 2048,
    localparam int WORDS  = BANK_BYTES / 2,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int LEN_W  = $clog2(BANK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we,
    input  logic [WIDX_W-1:0] buf_widx,
    input  logic [15:0]       buf_wdata,
    input  logic              start_req,
    input  logic [15:0]       start_len,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              busy
);
    tx_state_e        st_q, st_d;
    logic [WIDX_W:0]  pos_q;
    logic [LEN_W-1:0] tot_q;
    logic [15:0]      mem [WORDS];
    logic [15:0]      cur_word;
    logic             launch;

    assign launch = (st_q == TX_IDLE) && start_req && (start_len != 16'd0)
                    && (start_len <= 16'(BANK_BYTES));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE: if (launch) st_d = TX_SEND;
            TX_SEND: if (tx_ready && tx_last) st_d = TX_IDLE;
            default: st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        cur_word = mem[pos_q[WIDX_W:1]];
        tx_valid = (st_q == TX_SEND);
        tx_data  = pos_q[0] ? cur_word[15:8] : cur_word[7:0];
        tx_last  = tx_valid && ((LEN_W'(pos_q) + LEN_W'(1)) == tot_q);
        busy     = (st_q == TX_SEND);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            tot_q <= '0;
        end else if (launch) begin
            pos_q <= '0;
            tot_q <= start_len[LEN_W-1:0];
        end else if (st_q == TX_SEND && tx_ready && !tx_last) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we) mem[buf_widx] <= buf_wdata;
    end

    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> !busy && !tx_valid);

    a_r9_length_kept: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(tx_ready && tx_last) |=> $stable(tot_q));
endmodule

// File: rtl/efb_bus_regs.sv
module efb_bus_regs
    import efb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BANK_BYTES = 2048,
    parameter int OVF_W      = 16,
    localparam int WORDS  = BANK_BYTES / 2,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int LEN_W  = $clog2(BANK_BYTES + 1)
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    output logic [WIDX_W-1:0] word_idx,
    output logic              tx_buf_we,
    output logic              release_req,
    output logic              tx_start,
    input  logic [15:0]       rx_word,
    input  logic              rx_ready,
    input  logic              rx_err,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [OVF_W-1:0]  ovf_count,
    input  logic              tx_busy
);
    logic              in_rx, in_tx, in_reg;
    logic [ADDR_W-1:0] reg_off;

    always_comb begin
        in_rx    = cpu_addr < ADDR_W'(WORDS);
        in_tx    = !in_rx && (cpu_addr < ADDR_W'(2 * WORDS));
        in_reg   = !in_rx && !in_tx;
        reg_off  = cpu_addr - ADDR_W'(2 * WORDS);
        word_idx = cpu_addr[WIDX_W-1:0];

        tx_buf_we   = cpu_we && in_tx;
        release_req = cpu_we && in_reg && (reg_off == ADDR_W'(REG_RELEASE));
        tx_start    = cpu_we && in_reg && (reg_off == ADDR_W'(REG_TXLEN));

        cpu_rdata = '0;
        if (in_rx) begin
            cpu_rdata = rx_word;
        end else if (in_reg) begin
            if (reg_off == ADDR_W'(REG_STATUS)) begin
                cpu_rdata[ST_READY] = rx_ready;
                cpu_rdata[ST_ERR]   = rx_err;
                cpu_rdata[ST_BUSY]  = tx_busy;
            end else if (reg_off == ADDR_W'(REG_RXLEN)) begin
                cpu_rdata = 16'(rx_len);
            end else if (reg_off == ADDR_W'(REG_OVF)) begin
                cpu_rdata = 16'(ovf_count);
            end
        end
    end
endmodule

// File: rtl/efb_frame_buffer.sv
module efb_frame_buffer
    import efb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BANK_BYTES = 2048,
    parameter int OVF_W      = 16,
    localparam int WORDS  = BANK_BYTES / 2,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int LEN_W  = $clog2(BANK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    logic [WIDX_W-1:0] word_idx;
    logic              tx_buf_we, release_req, tx_start, rx_ready, rx_err, tx_busy;
    logic [15:0]       rx_word;
    logic [LEN_W-1:0]  rx_len;
    logic [OVF_W-1:0]  ovf_count;

    efb_bus_regs #(.ADDR_W(ADDR_W), .BANK_BYTES(BANK_BYTES), .OVF_W(OVF_W)) u_regs (
        .cpu_addr    (cpu_addr),
        .cpu_we      (cpu_we),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .word_idx    (word_idx),
        .tx_buf_we   (tx_buf_we),
        .release_req (release_req),
        .tx_start    (tx_start),
        .rx_word     (rx_word),
        .rx_ready    (rx_ready),
        .rx_err      (rx_err),
        .rx_len      (rx_len),
        .ovf_count   (ovf_count),
        .tx_busy     (tx_busy)
    );

    efb_rx_banks #(.BANK_BYTES(BANK_BYTES), .OVF_W(OVF_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_last     (rx_last),
        .release_req (release_req),
        .rd_widx     (word_idx),
        .rd_word     (rx_word),
        .rd_ready    (rx_ready),
        .rd_err      (rx_err),
        .rd_len      (rx_len),
        .ovf_count   (ovf_count)
    );

    efb_tx_drain #(.BANK_BYTES(BANK_BYTES)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_we    (tx_buf_we),
        .buf_widx  (word_idx),
        .buf_wdata (cpu_wdata),
        .start_req (tx_start),
        .start_len (cpu_wdata),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .busy      (tx_busy)
    );
endmodule

// File: tb/efb_frame_buffer_tb.sv
`timescale 1ns/1ps
module efb_frame_buffer_tb;
    localparam int BB    = 16;
    localparam int W     = BB / 2;
    localparam int A_ST  = 2 * W + 0;
    localparam int A_LEN = 2 * W + 1;
    localparam int A_REL = 2 * W + 2;
    localparam int A_TXL = 2 * W + 3;
    localparam int A_OVF = 2 * W + 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    efb_frame_buffer #(.ADDR_W(16), .BANK_BYTES(BB), .OVF_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    function automatic logic [7:0] pat(int s, int i);
        return 8'(s * 37 + i * 13 + 5);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(int a, int d);
        @(negedge clk);
        cpu_addr  = 16'(a);
        cpu_wdata = 16'(d);
        cpu_we    = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_read(int a, output logic [15:0] v);
        @(negedge clk);
        cpu_addr = 16'(a);
        #1;
        v = cpu_rdata;
    endtask

    task automatic send_frame(int len, int s);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pat(s, i);
            rx_last  = (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic check_frame(int len, int s, string tag);
        logic [15:0] v;
        int stored;
        stored = (len > BB) ? BB : len;
        cpu_read(A_ST, v);
        chk({tag, " R2 ready bit"}, 32'(v[0]), 32'd1);
        chk({tag, " R6 error bit"}, 32'(v[1]), (len > BB) ? 32'd1 : 32'd0);
        cpu_read(A_LEN, v);
        chk({tag, " R2/R6 length"}, 32'(v), 32'(stored));
        for (int w = 0; w < (stored + 1) / 2; w++) begin
            cpu_read(w, v);
            chk({tag, " R2 low byte"}, 32'(v[7:0]), 32'(pat(s, 2 * w)));
            if (2 * w + 1 < stored)
                chk({tag, " R2 high byte"}, 32'(v[15:8]), 32'(pat(s, 2 * w + 1)));
        end
    endtask

    task automatic load_tx(int s);
        for (int w = 0; w < W; w++)
            cpu_write(W + w, {pat(s, 2 * w + 1), pat(s, 2 * w)});
    endtask

    task automatic drain(int len, int s);
        logic [15:0] v;
        int n = 0;
        int cyc = 0;
        while (n < len && cyc < 400) begin
            @(negedge clk);
            tx_ready = (cyc % 3) != 2;
            cyc++;
            #1;
            if (!tx_valid) begin
                chk("R7 tx_valid during frame", 32'(tx_valid), 32'd1);
                n = len;
            end else begin
                chk("R8 tx_data at position", 32'(tx_data), 32'(pat(s, n)));
                if (tx_ready) begin
                    chk("R7 tx_last position", 32'(tx_last), (n == len - 1) ? 32'd1 : 32'd0);
                    n++;
                end
            end
        end
        @(negedge clk);
        tx_ready = 1'b0;
        #1;
        chk("R8 tx_valid low after last", 32'(tx_valid), 32'd0);
        cpu_read(A_ST, v);
        chk("R8 busy clear after last", 32'(v[2]), 32'd0);
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cpu_read(A_ST, v);  chk("R1 status", 32'(v), 32'd0);
        cpu_read(A_LEN, v); chk("R1 rx length", 32'(v), 32'd0);
        cpu_read(A_OVF, v); chk("R1 overflow", 32'(v), 32'd0);
        chk("R1 tx_valid", 32'(tx_valid), 32'd0);

        // R2/R6/R4 sweep of lengths, each released
        for (int L = 1; L <= BB + 4; L++) begin
            send_frame(L, L);
            check_frame(L, L, "sweep");
            cpu_write(A_REL, 0);
            cpu_read(A_ST, v);
            chk("R4 ready clears on release", 32'(v[0]), 32'd0);
        end

        // R3 alternation and order
        send_frame(5, 20);
        send_frame(9, 21);
        check_frame(5, 20, "R3 first");
        cpu_write(A_REL, 0);
        check_frame(9, 21, "R3 second");
        cpu_write(A_REL, 0);

        // R5 drop when both banks held, saturation
        send_frame(7, 30);
        send_frame(12, 31);
        send_frame(6, 32);
        cpu_read(A_OVF, v); chk("R5 overflow one", 32'(v), 32'd1);
        check_frame(7, 30, "R5 held first");
        for (int k = 0; k < 16; k++) send_frame(3, 33 + k);
        cpu_read(A_OVF, v); chk("R5 overflow saturates", 32'(v), 32'd15);
        check_frame(7, 30, "R5 held first again");
        cpu_write(A_REL, 0);
        check_frame(12, 31, "R5 held second");
        cpu_write(A_REL, 0);
        cpu_read(A_ST, v); chk("R5 both free", 32'(v[0]), 32'd0);

        // R4 release while empty has no effect
        cpu_write(A_REL, 0);
        cpu_read(A_ST, v); chk("R4 idle release status", 32'(v), 32'd0);
        send_frame(3, 40);
        send_frame(6, 41);
        check_frame(3, 40, "R4 order first");
        cpu_write(A_REL, 0);
        check_frame(6, 41, "R4 order second");
        cpu_write(A_REL, 0);

        // R7/R8 transmit sweep
        for (int L = 1; L <= BB; L++) begin
            load_tx(60 + L);
            cpu_write(A_TXL, L);
            cpu_read(A_ST, v);
            chk("R7 busy after start", 32'(v[2]), 32'd1);
            drain(L, 60 + L);
        end

        // R9 ignored length writes
        load_tx(90);
        cpu_write(A_TXL, 4);
        cpu_write(A_TXL, 9);
        drain(4, 90);
        cpu_write(A_TXL, 0);
        #1;
        chk("R9 zero length tx_valid", 32'(tx_valid), 32'd0);
        cpu_read(A_ST, v); chk("R9 zero length busy", 32'(v[2]), 32'd0);
        cpu_write(A_TXL, BB + 1);
        #1;
        chk("R9 oversize tx_valid", 32'(tx_valid), 32'd0);
        cpu_read(A_ST, v); chk("R9 oversize busy", 32'(v[2]), 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule